// File: doc/BRIEF.md
# Keyed Write-Protection Gate

This block sits between a host write port and a page-write buffer and decides, write by write, whether the buffer gets the data. It keeps a protection flag. It watches every (address, data) write for two fixed key sequences. A three-write key turns protection on. A six-write key turns it off. While protection is on, ordinary writes are dropped. The one exception is that the three-write key also opens a single page window: up to `PAGE_BYTES` writes that follow it go through, and protection stays on afterwards.

Key writes are never forwarded, so the page buffer never stores them. Each key write gives a one-cycle consume pulse. If a write breaks a partial key, the matcher goes back to idle; when protection is off, that write goes to the buffer as ordinary data. If `GAP_CYC` clock cycles pass with no write, a partial key is abandoned and an open page window is closed. The protection flag stands in for a nonvolatile latch: the logic reset does not touch it, and at power-up it comes up clear (unprotected).

Top module: `wlg_gate`

## Requirements
- R1: Writing AAh to 1555h, then 55h to 0AAAh, then A0h to 1555h sets `prot_o`. `prot_o` reads 1 in the cycle after the third write is sampled. `prot_chg` pulses for that one cycle if the flag was clear before.
- R2: Writing AAh to 1555h, 55h to 0AAAh, 80h to 1555h, AAh to 1555h, 55h to 0AAAh, then 20h to 1555h clears `prot_o` in the cycle after the sixth write. `prot_chg` pulses for one cycle if the flag was set before.
- R3: While `prot_o` is 1 and no page window is open, a write that is not a key write gives no `pass_vld`.
- R4: After a completed enable key, the next writes, up to `PAGE_BYTES` of them, are forwarded whatever their value, and `prot_o` stays 1. Once `PAGE_BYTES` writes have been forwarded, the window is closed.
- R5: A write accepted as a key step is never forwarded. It gives `key_eat` = 1 in the following cycle.
- R6: While unprotected, a non-key write is forwarded one cycle later. `pass_vld` = 1, and `pass_addr` and `pass_data` equal the write's address and data.
- R7: A write that does not match the next key step aborts the partial key. If that write is itself AAh to 1555h, it is consumed as the first step of a new key. Otherwise, it is forwarded when unprotected and dropped when protected.
- R8: After `GAP_CYC` consecutive cycles with no write, a partial key is abandoned and an open page window is closed. A gap of `GAP_CYC`-1 idle cycles abandons nothing.
- R9: `prot_o` is 0 at power-up and keeps its value through `rst_n` assertion. `rst_n` clears the key matcher, the page window and all pulses.
- R10: An enable key while protected, or a disable key while unprotected, gives no `prot_chg`. Its writes are still consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the matcher and window (not the flag) |
| wr_valid | input | 1 | A host write is present this cycle |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data |
| pass_vld | output | 1 | Forwarded write strobe to the page buffer |
| pass_addr | output | 13 | Forwarded address, valid with `pass_vld` |
| pass_data | output | 8 | Forwarded data, valid with `pass_vld` |
| prot_o | output | 1 | Protection flag |
| key_eat | output | 1 | Pulse: previous write was consumed as a key step |
| prot_chg | output | 1 | Pulse: protection flag just changed |

## Verification
All results are registered once. `pass_vld`/`pass_addr`/`pass_data`, `key_eat`, `prot_chg` and the new `prot_o` value are due in the cycle after the clock edge that samples the write. The timeout takes effect at the edge that ends the `GAP_CYC`-th idle cycle, so a write presented after that sees an idle matcher. The bench drives each cycle's inputs at the falling edge and updates its behavioural model with those same inputs. At the next falling edge it compares every output with the model's prediction, so each comparison covers exactly one register stage.

// File: rtl/wlg_pkg.sv
package wlg_pkg;
  localparam int AW = 13;
  localparam int DW = 8;

  localparam logic [AW-1:0] KEY_ADR_HI = 13'h1555;
  localparam logic [AW-1:0] KEY_ADR_LO = 13'h0AAA;
  localparam logic [DW-1:0] KEY_B_LEAD = 8'hAA;
  localparam logic [DW-1:0] KEY_B_MID  = 8'h55;
  localparam logic [DW-1:0] KEY_B_SET  = 8'hA0;
  localparam logic [DW-1:0] KEY_B_OFF1 = 8'h80;
  localparam logic [DW-1:0] KEY_B_OFF2 = 8'h20;

  typedef enum logic [2:0] {
    KS_IDLE, KS_A1, KS_A2, KS_B3, KS_B4, KS_B5
  } kstep_e;

  typedef struct packed {
    logic   hit;
    logic   en_fin;
    logic   dis_fin;
    kstep_e nxt;
  } kres_t;

  function automatic logic is_wr(logic [AW-1:0] a, logic [DW-1:0] d,
                                 logic [AW-1:0] ka, logic [DW-1:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  // Next-step decision for one write against the current key position.
  function automatic kres_t key_eval(kstep_e st, logic [AW-1:0] a, logic [DW-1:0] d);
    kres_t r;
    r = '{hit: 1'b0, en_fin: 1'b0, dis_fin: 1'b0, nxt: KS_IDLE};
    unique case (st)
      KS_IDLE: if (is_wr(a, d, KEY_ADR_HI, KEY_B_LEAD)) begin r.hit = 1'b1; r.nxt = KS_A1; end
      KS_A1:   if (is_wr(a, d, KEY_ADR_LO, KEY_B_MID))  begin r.hit = 1'b1; r.nxt = KS_A2; end
      KS_A2: begin
        if (is_wr(a, d, KEY_ADR_HI, KEY_B_SET)) begin
          r.hit = 1'b1; r.en_fin = 1'b1; r.nxt = KS_IDLE;
        end else if (is_wr(a, d, KEY_ADR_HI, KEY_B_OFF1)) begin
          r.hit = 1'b1; r.nxt = KS_B3;
        end
      end
      KS_B3:   if (is_wr(a, d, KEY_ADR_HI, KEY_B_LEAD)) begin r.hit = 1'b1; r.nxt = KS_B4; end
      KS_B4:   if (is_wr(a, d, KEY_ADR_LO, KEY_B_MID))  begin r.hit = 1'b1; r.nxt = KS_B5; end
      KS_B5: if (is_wr(a, d, KEY_ADR_HI, KEY_B_OFF2)) begin
        r.hit = 1'b1; r.dis_fin = 1'b1; r.nxt = KS_IDLE;
      end
      default: r.nxt = KS_IDLE;
    endcase
    // A broken sequence may itself be the opening write of a new key.
    if (!r.hit && is_wr(a, d, KEY_ADR_HI, KEY_B_LEAD)) begin
      r.hit = 1'b1;
      r.nxt = KS_A1;
    end
    return r;
  endfunction
endpackage

// File: rtl/wlg_gap_timer.sv
module wlg_gap_timer #(
  parameter int GAP_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic wr,
  output logic expire
);
  localparam int TW = $clog2(GAP_CYC + 1);
  logic [TW-1:0] cnt_q;

  // R8: idle cycles counted only while a key or page window is pending
  assign expire = armed && !wr && (cnt_q == TW'(GAP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (wr || !armed || expire) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wlg_seq_match.sv
module wlg_seq_match
  import wlg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          bypass,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          expire,
  output logic          consume,
  output logic          en_done,
  output logic          dis_done,
  output logic          busy
);
  kstep_e step_q;
  kres_t  res;
  logic   look;

  assign look     = wr && !bypass && rst_n;
  assign res      = key_eval(step_q, addr, data);
  assign consume  = look && res.hit;      // R5
  assign en_done  = look && res.en_fin;   // R1
  assign dis_done = look && res.dis_fin;  // R2
  assign busy     = (step_q != KS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= KS_IDLE;
    else if (expire) step_q <= KS_IDLE;   // R8
    else if (look)   step_q <= res.nxt;   // R7 on a miss
  end
endmodule

// File: rtl/wlg_page_window.sv
module wlg_page_window #(
  parameter int PAGE_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic wr,
  input  logic expire,
  output logic win_open
);
  localparam int CW = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      cnt_q    <= '0;
    end else if (open_req) begin
      win_open <= 1'b1;
      cnt_q    <= '0;
    end else if (win_open && wr) begin
      // R4: close after the last permitted page byte
      if (cnt_q == CW'(PAGE_BYTES - 1)) win_open <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end else if (expire) begin
      win_open <= 1'b0;
    end
  end
endmodule

// File: rtl/wlg_gate.sv
module wlg_gate
  import wlg_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int GAP_CYC    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pass_vld,
  output logic [AW-1:0] pass_addr,
  output logic [DW-1:0] pass_data,
  output logic          prot_o,
  output logic          key_eat,
  output logic          prot_chg
);
  logic key_hit, en_done, dis_done, seq_busy, win_open, timeout, pass_now;
  // R9: flag models a nonvolatile latch: power-up clear, untouched by rst_n
  logic prot_q = 1'b0;

  wlg_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .armed(seq_busy || win_open),
    .wr(wr_valid), .expire(timeout)
  );

  wlg_seq_match u_seq (
    .clk(clk), .rst_n(rst_n), .wr(wr_valid), .bypass(win_open),
    .addr(wr_addr), .data(wr_data), .expire(timeout),
    .consume(key_hit), .en_done(en_done), .dis_done(dis_done), .busy(seq_busy)
  );

  wlg_page_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
    .clk(clk), .rst_n(rst_n), .open_req(en_done), .wr(wr_valid),
    .expire(timeout), .win_open(win_open)
  );

  // R3/R4/R6: forward page data, or plain data while unprotected
  assign pass_now = wr_valid && rst_n && (win_open || (!key_hit && !prot_q));

  always_ff @(posedge clk) begin
    if (en_done)       prot_q <= 1'b1;
    else if (dis_done) prot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_vld  <= 1'b0;
      pass_addr <= '0;
      pass_data <= '0;
      key_eat   <= 1'b0;
      prot_chg  <= 1'b0;
    end else begin
      pass_vld <= pass_now;
      if (pass_now) begin
        pass_addr <= wr_addr;
        pass_data <= wr_data;
      end
      key_eat  <= key_hit;
      // R10: pulse only on an actual change
      prot_chg <= (en_done && !prot_q) || (dis_done && prot_q);
    end
  end

  assign prot_o = prot_q;
endmodule

// File: rtl/wlg_chk.sv
module wlg_chk
  import wlg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          pass_vld,
  input logic [AW-1:0] pass_addr,
  input logic          prot_o,
  input logic          key_eat,
  input logic          prot_chg,
  input logic          key_hit,
  input logic          en_done,
  input logic          dis_done,
  input logic          win_open,
  input logic          timeout
);
  // R1
  en_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_done |=> prot_o);
  // R2
  dis_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_done |=> !prot_o);
  // R3
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && prot_o && !win_open && !key_hit) |=> !pass_vld);
  // R4
  page_window_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && win_open) |=> (pass_vld && pass_addr == $past(wr_addr)));
  // R5
  key_withheld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> (key_eat && !pass_vld));
  // R6
  open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !prot_o && !key_hit) |=> (pass_vld && pass_addr == $past(wr_addr)));
  // R8
  timeout_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !win_open);
  // R10
  chg_means_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_chg |-> (prot_o != $past(prot_o)));
endmodule

bind wlg_gate wlg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .pass_vld(pass_vld), .pass_addr(pass_addr), .prot_o(prot_o),
  .key_eat(key_eat), .prot_chg(prot_chg), .key_hit(key_hit),
  .en_done(en_done), .dis_done(dis_done), .win_open(win_open), .timeout(timeout)
);

// File: tb/wlg_gate_test.sv
`timescale 1ns/1ps
module wlg_gate_test;
  localparam int PAGE = 64;
  localparam int GAP  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pass_vld, prot_o, key_eat, prot_chg;
  logic [12:0] pass_addr;
  logic [7:0]  pass_data;

  always #2 clk = ~clk;

  wlg_gate #(.PAGE_BYTES(PAGE), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .pass_vld(pass_vld), .pass_addr(pass_addr),
    .pass_data(pass_data), .prot_o(prot_o), .key_eat(key_eat), .prot_chg(prot_chg)
  );

  int checks = 0, fails = 0;
  string cur_req = "R9";
  bit done = 0;

  // behavioural model
  bit       m_prot = 0;
  bit [7:0] kq[$];
  bit       m_win = 0;
  int       m_cnt = 0, m_gap = 0;
  bit       e_pass = 0, e_eat = 0, e_chg = 0;
  bit [12:0] e_a = 0;
  bit [7:0]  e_d = 0;

  function automatic bit key_ok(int idx, bit [12:0] a, bit [7:0] d);
    bit [12:0] ka[6] = '{13'h1555, 13'h0AAA, 13'h1555, 13'h1555, 13'h0AAA, 13'h1555};
    bit [7:0]  kd[6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
    if (idx == 2 && a == 13'h1555 && d == 8'hA0) return 1;
    return (a == ka[idx]) && (d == kd[idx]);
  endfunction

  task automatic model(bit v, bit [12:0] a, bit [7:0] d, bit run);
    e_pass = 0; e_eat = 0; e_chg = 0;
    if (!run) begin kq.delete(); m_win = 0; m_gap = 0; m_cnt = 0; return; end
    if (v) begin
      m_gap = 0;
      if (m_win) begin
        e_pass = 1; e_a = a; e_d = d; m_cnt++;
        if (m_cnt == PAGE) m_win = 0;
      end else if (key_ok(kq.size(), a, d)) begin
        kq.push_back(d); e_eat = 1;
        if (kq.size() == 3 && d == 8'hA0) begin
          kq.delete(); m_win = 1; m_cnt = 0;
          if (!m_prot) e_chg = 1;
          m_prot = 1;
        end else if (kq.size() == 6) begin
          kq.delete();
          if (m_prot) e_chg = 1;
          m_prot = 0;
        end
      end else if (key_ok(0, a, d)) begin
        kq.delete(); kq.push_back(d); e_eat = 1;
      end else begin
        kq.delete();
        if (!m_prot) begin e_pass = 1; e_a = a; e_d = d; end
      end
    end else if (kq.size() > 0 || m_win) begin
      m_gap++;
      if (m_gap == GAP) begin kq.delete(); m_win = 0; m_gap = 0; end
    end
  endtask

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(prot_o === m_prot, "prot_o", prot_o, m_prot);
    chk(pass_vld === e_pass, "pass_vld", pass_vld, e_pass);
    if (e_pass) begin
      chk(pass_addr === e_a, "pass_addr", pass_addr, e_a);
      chk(pass_data === e_d, "pass_data", pass_data, e_d);
    end
    chk(key_eat === e_eat, "key_eat", key_eat, e_eat);
    chk(prot_chg === e_chg, "prot_chg", prot_chg, e_chg);
  endtask

  task automatic step(bit v, bit [12:0] a, bit [7:0] d, bit run = 1);
    @(negedge clk);
    compare();
    rst_n = run; wr_valid = v; wr_addr = a; wr_data = d;
    model(v, a, d, run);
  endtask

  task automatic wr(bit [12:0] a, bit [7:0] d); step(1, a, d); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(0, 0, 0); endtask
  task automatic do_reset(); for (int i = 0; i < 3; i++) step(0, 0, 0, 0); endtask
  task automatic key_en();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
  endtask
  task automatic key_dis();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
  endtask

  initial begin
    cur_req = "R9";
    do_reset(); idle(2);
    @(negedge clk);
    chk(prot_o === 1'b0, "power-up flag", prot_o, 0);

    cur_req = "R6";
    wr(13'h0000, 8'h00); wr(13'h1FFF, 8'hFF); wr(13'h0A5A, 8'h3C); idle(1);
    wr(13'h1555, 8'h55); wr(13'h0AAA, 8'hAA); idle(2);

    cur_req = "R1";
    key_en();
    cur_req = "R4";
    wr(13'h0040, 8'h11); wr(13'h0041, 8'h22); wr(13'h1555, 8'hAA);
    cur_req = "R8";
    idle(GAP + 1);
    cur_req = "R3";
    wr(13'h0100, 8'h77); wr(13'h0101, 8'h78); idle(2);

    cur_req = "R4";
    key_en();
    for (int i = 0; i < PAGE + 2; i++) wr(13'h0200 + 13'(i), 8'(i * 3 + 1));
    idle(GAP + 1);

    cur_req = "R10";
    key_en(); idle(GAP + 1);

    cur_req = "R9";
    do_reset(); idle(2);
    @(negedge clk);
    chk(prot_o === 1'b1, "flag kept through reset", prot_o, 1);

    cur_req = "R8";
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); idle(GAP - 1); wr(13'h1555, 8'hA0);
    wr(13'h0300, 8'h99); idle(GAP + 1);

    cur_req = "R2";
    key_dis(); idle(1);
    cur_req = "R10";
    key_dis(); idle(1);

    cur_req = "R7";
    wr(13'h1555, 8'hAA); wr(13'h0100, 8'h12);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'hAA); wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
    idle(GAP + 1);
    cur_req = "R5";
    key_dis(); idle(1);

    cur_req = "R8";
    wr(13'h1555, 8'hAA); idle(GAP); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
    idle(2);

    step(0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule